// File: doc/BRIEF.md
# Output Compare Timer Channel

This block is a single timer channel that schedules one output event. The host first loads a setup word that chooses which of two free-running 16-bit time bases to sample and which to compare against, what to do to the output pin on a match, and whether to force the pin at start-up. It also loads an offset. A service request with code 01 then arms the channel. On that request the channel samples the capture time base as its reference, adds the offset to form the target time, and may force the pin high or low at once.

While armed, the channel compares the chosen match time base with the target on every clock. When they are equal, the channel acts on the pin at the next clock edge: it leaves the pin alone, drives it high, drives it low, or toggles it. In the same edge it records the time-base value and raises an interrupt flag, which stays set until the host acknowledges it. After a match the channel goes idle and does nothing more until the host sends another service request.

The time bases themselves come from outside, so one timer pair can feed many channels. Setup fields whose codes mean "keep" leave the stored setting as it is. This lets a host write one field of the setup word without disturbing the others.

Top module: `oc_match_chan`

## Requirements
- R1: After reset, pin_out, irq and armed are 0, and target_time and match_time are 0.
- R2: A cycle with svc_we=1 and svc_code=01 samples the capture base (tbase_a when the stored capture select is 0, tbase_b when it is 1). At that edge it loads target_time with the sampled value plus the stored offset, modulo 2^W, and sets armed.
- R3: An offset written through cfg_ofs that is greater than 2^(W-1) (0x8000 for W=16) is stored as 2^(W-1). Smaller values are stored as written.
- R4: A cycle with armed=1 and the match base equal to target_time is a hit. The match base is tbase_a when the stored match select is 0 and tbase_b when it is 1. At the next edge match_time takes the match base value, irq goes to 1 and armed goes to 0. Equality on the other base causes no hit. An initialization in the same cycle takes priority over a hit.
- R5: On a hit the pin follows the stored 2-bit action: 00 leaves it unchanged, 01 drives it high, 10 drives it low, 11 toggles it.
- R6: cfg_we writes the fields. cfg_tbs of the form 01xy stores capture select x and match select y. Any other cfg_tbs value keeps both selects. cfg_act with bit 2 clear stores cfg_act[1:0], and with bit 2 set keeps the stored action. cfg_frc and the offset are always stored.
- R7: At an initialization the stored force code acts on the pin at the same edge: 01 drives it high, 10 drives it low, and 11 or 00 leave it unchanged.
- R8: Service codes 00, 10 and 11 have no effect. After a hit the channel does not fire again until a new 01 request, even if the match base stays equal to the target.
- R9: irq_ack=1 clears irq at the next edge. A hit in the same cycle wins and irq stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_a | input | W | First time base |
| tbase_b | input | W | Second time base |
| cfg_we | input | 1 | Setup write strobe |
| cfg_tbs | input | 4 | Time-base select code (01xy: capture x, match y) |
| cfg_act | input | 3 | Match action code (bit 2 set keeps the stored action) |
| cfg_frc | input | 2 | Pin force code applied at initialization |
| cfg_ofs | input | W | Offset added to the reference |
| svc_we | input | 1 | Service request strobe |
| svc_code | input | 2 | Service request code (01 initializes) |
| irq_ack | input | 1 | Interrupt acknowledge |
| pin_out | output | 1 | Channel output pin |
| irq | output | 1 | Interrupt flag |
| armed | output | 1 | Channel waiting for a match |
| target_time | output | W | Reference plus offset |
| match_time | output | W | Time-base value recorded at the last match |

## Verification
The bench builds the block with the default W=16, so the real limits are tested directly. These are the offset clamp at 0x8000, a reference near the top of the range whose sum wraps past 0xFFFF, and both time bases driven independently by the bench. Because the bench sets the two bases to unrelated values, it can check each of the four capture/match pairings. It does this by making the wrong base equal the target and confirming that nothing happens.

// File: rtl/oc_match_chan.sv
module oc_match_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tbase_a,
  input  logic [W-1:0] tbase_b,
  input  logic         cfg_we,
  input  logic [3:0]   cfg_tbs,
  input  logic [2:0]   cfg_act,
  input  logic [1:0]   cfg_frc,
  input  logic [W-1:0] cfg_ofs,
  input  logic         svc_we,
  input  logic [1:0]   svc_code,
  input  logic         irq_ack,
  output logic         pin_out,
  output logic         irq,
  output logic         armed,
  output logic [W-1:0] target_time,
  output logic [W-1:0] match_time
);

  localparam logic [W-1:0] OFS_LIM = {1'b1, {(W-1){1'b0}}};

  logic         cap_sel, mat_sel;
  logic [1:0]   act_q, frc_q;
  logic [W-1:0] ofs_q;
  logic [W-1:0] cap_val, mat_val, ofs_in;
  logic         init, hit;

  assign cap_val = cap_sel ? tbase_b : tbase_a;
  assign mat_val = mat_sel ? tbase_b : tbase_a;
  assign ofs_in  = (cfg_ofs > OFS_LIM) ? OFS_LIM : cfg_ofs;
  assign init    = svc_we && (svc_code == 2'b01);
  assign hit     = armed && !init && (mat_val == target_time);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sel <= 1'b0;
      mat_sel <= 1'b0;
      act_q   <= 2'b00;
      frc_q   <= 2'b11;
      ofs_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_tbs[3:2] == 2'b01) begin
        cap_sel <= cfg_tbs[1];
        mat_sel <= cfg_tbs[0];
      end
      if (!cfg_act[2]) act_q <= cfg_act[1:0];
      frc_q <= cfg_frc;
      ofs_q <= ofs_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      target_time <= '0;
      match_time  <= '0;
      irq         <= 1'b0;
      pin_out     <= 1'b0;
    end else begin
      if (init) begin
        armed       <= 1'b1;
        target_time <= cap_val + ofs_q;
        case (frc_q)
          2'b01:   pin_out <= 1'b1;
          2'b10:   pin_out <= 1'b0;
          default: pin_out <= pin_out;
        endcase
      end else if (hit) begin
        armed      <= 1'b0;
        match_time <= mat_val;
        case (act_q)
          2'b01:   pin_out <= 1'b1;
          2'b10:   pin_out <= 1'b0;
          2'b11:   pin_out <= ~pin_out;
          default: pin_out <= pin_out;
        endcase
      end
      if (hit)          irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/oc_match_chan_chk.sv
module oc_match_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tbase_a,
  input logic [W-1:0] tbase_b,
  input logic         svc_we,
  input logic [1:0]   svc_code,
  input logic         irq_ack,
  input logic         cap_sel,
  input logic         mat_sel,
  input logic [1:0]   frc_q,
  input logic [W-1:0] ofs_q,
  input logic         pin_out,
  input logic         irq,
  input logic         armed,
  input logic [W-1:0] target_time,
  input logic [W-1:0] match_time
);

  localparam logic [W-1:0] OFS_LIM = {1'b1, {(W-1){1'b0}}};

  logic         go;
  logic [W-1:0] want_t;
  logic [W-1:0] mbase;

  assign go     = svc_we && (svc_code == 2'b01);
  assign want_t = (cap_sel ? tbase_b : tbase_a) + ofs_q;
  assign mbase  = mat_sel ? tbase_b : tbase_a;

  p_init_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> armed && target_time == $past(want_t));

  p_ofs_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_q <= OFS_LIM);

  p_hit_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !go && mbase == target_time) |=> irq && !armed && match_time == $past(target_time));

  p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && frc_q == 2'b01) |=> pin_out);

  p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && frc_q == 2'b10) |=> !pin_out);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !go) |=> !armed && $stable(match_time) && $stable(pin_out));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !armed) |=> !irq);

endmodule

bind oc_match_chan oc_match_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tbase_a(tbase_a), .tbase_b(tbase_b),
  .svc_we(svc_we), .svc_code(svc_code), .irq_ack(irq_ack),
  .cap_sel(cap_sel), .mat_sel(mat_sel), .frc_q(frc_q), .ofs_q(ofs_q),
  .pin_out(pin_out), .irq(irq), .armed(armed),
  .target_time(target_time), .match_time(match_time)
);

// File: tb/oc_match_chan_test.sv
`timescale 1ns/1ps
module oc_match_chan_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] ta = '0, tb = '0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_tbs = 4'b0100;
  logic [2:0]   cfg_act = 3'b000;
  logic [1:0]   cfg_frc = 2'b11;
  logic [W-1:0] cfg_ofs = '0;
  logic         svc_we = 1'b0;
  logic [1:0]   svc_code = 2'b00;
  logic         irq_ack = 1'b0;
  logic         pin_out, irq, armed;
  logic [W-1:0] target_time, match_time;

  int checks = 0;
  int errors = 0;
  logic exp_pin = 1'b0;

  always #2.5 clk = ~clk;

  oc_match_chan #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tbase_a(ta), .tbase_b(tb),
    .cfg_we(cfg_we), .cfg_tbs(cfg_tbs), .cfg_act(cfg_act), .cfg_frc(cfg_frc),
    .cfg_ofs(cfg_ofs), .svc_we(svc_we), .svc_code(svc_code), .irq_ack(irq_ack),
    .pin_out(pin_out), .irq(irq), .armed(armed),
    .target_time(target_time), .match_time(match_time)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cfg(input logic [3:0] t, input logic [2:0] a, input logic [1:0] f, input logic [W-1:0] o);
    cfg_we = 1'b1; cfg_tbs = t; cfg_act = a; cfg_frc = f; cfg_ofs = o;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_svc(input logic [1:0] c);
    svc_we = 1'b1; svc_code = c;
    step();
    svc_we = 1'b0; svc_code = 2'b00;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pin", W'(pin_out), 0);
    chk("R1 irq", W'(irq), 0);
    chk("R1 armed", W'(armed), 0);
    chk("R1 target", target_time, 0);
    chk("R1 match", match_time, 0);
  endtask

  task automatic t_basic();
    ta = 16'h0100; tb = 16'h0000;
    do_cfg(4'b0100, 3'b011, 2'b11, 16'h0010);
    do_svc(2'b01);
    chk("R2 target", target_time, 16'h0110);
    chk("R2 armed", W'(armed), 1);
    chk("R7 no force", W'(pin_out), W'(exp_pin));
    ta = 16'h010F; step();
    chk("R4 near miss", W'(irq), 0);
    tb = 16'h0110; step();
    chk("R4 other base", W'(irq), 0);
    ta = 16'h0110; step();
    exp_pin = ~exp_pin;
    chk("R4 irq", W'(irq), 1);
    chk("R4 disarm", W'(armed), 0);
    chk("R4 match_time", match_time, 16'h0110);
    chk("R5 toggle", W'(pin_out), W'(exp_pin));
    step();
    do_ack();
    chk("R9 ack", W'(irq), 0);
    step();
    chk("R8 no refire irq", W'(irq), 0);
    chk("R8 no refire pin", W'(pin_out), W'(exp_pin));
  endtask

  task automatic t_wrap();
    ta = 16'h9000;
    do_cfg(4'b0100, 3'b011, 2'b11, 16'hFFFF);
    do_svc(2'b01);
    chk("R3 clamp+wrap", target_time, 16'h1000);
    ta = 16'h1000; step();
    exp_pin = ~exp_pin;
    chk("R4 wrap hit", W'(irq), 1);
    chk("R5 toggle back", W'(pin_out), W'(exp_pin));
    do_ack();
    ta = 16'h0001;
    do_cfg(4'b0100, 3'b000, 2'b11, 16'h8000);
    do_svc(2'b01);
    chk("R3 limit exact", target_time, 16'h8001);
    ta = 16'hFFF0;
    do_cfg(4'b0100, 3'b000, 2'b11, 16'h7FFF);
    do_svc(2'b01);
    chk("R2 wrap sum", target_time, 16'h7FEF);
    ta = 16'h7FEF; step();
    do_ack();
  endtask

  task automatic t_cross();
    ta = 16'h0000; tb = 16'h0200;
    do_cfg(4'b0110, 3'b001, 2'b11, 16'h0005);
    do_svc(2'b01);
    chk("R2 capture b", target_time, 16'h0205);
    tb = 16'h0205; step();
    chk("R4 match a only", W'(irq), 0);
    ta = 16'h0205; step();
    exp_pin = 1'b1;
    chk("R4 match a hit", W'(irq), 1);
    chk("R5 high", W'(pin_out), W'(exp_pin));
    do_ack();
    ta = 16'h0400; tb = 16'h0000;
    do_cfg(4'b0101, 3'b010, 2'b11, 16'h0003);
    do_svc(2'b01);
    chk("R2 capture a", target_time, 16'h0403);
    ta = 16'h0403; step();
    chk("R4 match b only", W'(irq), 0);
    tb = 16'h0403; step();
    exp_pin = 1'b0;
    chk("R4 match b hit", W'(irq), 1);
    chk("R5 low", W'(pin_out), W'(exp_pin));
    do_ack();
  endtask

  task automatic t_force();
    ta = 16'h0050; tb = 16'h0000;
    exp_pin = 1'b1;
    do_cfg(4'b0100, 3'b001, 2'b01, 16'h0001);
    do_svc(2'b01);
    chk("R7 force high", W'(pin_out), 1);
    do_cfg(4'b0100, 3'b000, 2'b10, 16'h0004);
    do_svc(2'b01);
    exp_pin = 1'b0;
    chk("R7 force low", W'(pin_out), W'(exp_pin));
    ta = 16'h0054; step();
    chk("R5 none irq", W'(irq), 1);
    chk("R5 none pin", W'(pin_out), W'(exp_pin));
    do_ack();
    ta = 16'h0060;
    do_cfg(4'b0100, 3'b010, 2'b01, 16'h0004);
    do_svc(2'b01);
    chk("R7 force high 2", W'(pin_out), 1);
    ta = 16'h0064; step();
    exp_pin = 1'b0;
    chk("R5 low after force", W'(pin_out), W'(exp_pin));
    do_ack();
  endtask

  task automatic t_keep();
    do_cfg(4'b0111, 3'b001, 2'b11, 16'h0001);
    do_cfg(4'b1000, 3'b110, 2'b11, 16'h0001);
    do_cfg(4'b0011, 3'b100, 2'b11, 16'h0002);
    ta = 16'h0060; tb = 16'h0070;
    do_svc(2'b01);
    chk("R6 capture kept", target_time, 16'h0072);
    ta = 16'h0072; step();
    chk("R6 match kept", W'(irq), 0);
    tb = 16'h0072; step();
    exp_pin = 1'b1;
    chk("R6 hit", W'(irq), 1);
    chk("R6 action kept", W'(pin_out), W'(exp_pin));
    do_ack();
  endtask

  task automatic t_ignore();
    logic [W-1:0] t0;
    t0 = target_time;
    do_cfg(4'b0100, 3'b011, 2'b01, 16'h0009);
    ta = 16'h0300;
    do_svc(2'b10);
    chk("R8 code10 armed", W'(armed), 0);
    do_svc(2'b11);
    do_svc(2'b00);
    chk("R8 codes armed", W'(armed), 0);
    chk("R8 codes target", target_time, t0);
    chk("R8 codes pin", W'(pin_out), W'(exp_pin));
  endtask

  task automatic t_race();
    ta = 16'h0080;
    do_cfg(4'b0100, 3'b011, 2'b11, 16'h0003);
    do_svc(2'b01);
    ta = 16'h0083;
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    exp_pin = ~exp_pin;
    chk("R9 set wins", W'(irq), 1);
    chk("R5 race toggle", W'(pin_out), W'(exp_pin));
    do_ack();
    chk("R9 later ack", W'(irq), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_basic();
    t_wrap();
    t_cross();
    t_force();
    t_keep();
    t_ignore();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule